// File: doc/BRIEF.md
# External Memory Wait-State Generator

This block lengthens each external memory access by a programmable number of wait cycles. It holds one 8-bit control register with two independent 3-bit wait counts: one for accesses to program memory and one for accesses to data memory. The access requester raises a one-cycle request strobe together with a type flag. The generator then asserts a stall output for exactly the selected number of cycles and follows it with a one-cycle done pulse.

The block runs on the undivided internal clock, so every wait cycle is one internal-clock period, even when the CPU itself runs on a prescaled clock. The same register also stores a watchdog-enable bit, which is only exported. At reset the register holds its most cautious setting: both wait counts are at their maximum of 7 and the watchdog-enable bit is set.

The sequencer has three states:
- IDLE: no access is in progress.
- WAIT: stall is asserted and the loaded count is decremented.
- DONE: the one-cycle completion pulse.

Its transitions are as follows:
- From IDLE or DONE, an accepted request goes to WAIT when the selected count is nonzero, and to DONE when it is zero.
- WAIT moves to DONE when the count reaches 1.
- DONE returns to IDLE when no request is present.

Top module: `memwait_gen`

## Requirements
- R1: After reset, cfg_rdata reads 8'h7F, wdog_en is 1, and stall and done are both 0.
- R2: A write stores cfg_wdata bits 6:0. Bit 7 of cfg_rdata always reads 0, whatever value is written.
- R3: A request with acc_is_prog=0 (data access) asserts stall for exactly N cycles, where N is register bits 5:3. Stall starts in the cycle after the request. Done is high for one cycle immediately after the last stall cycle.
- R4: A request with acc_is_prog=1 (program access) behaves the same way, but N is register bits 2:0.
- R5: When the selected count is 0, stall is never raised and done is high in the cycle right after the request.
- R6: The count is captured when the request is accepted. A register write during the access does not change that access's stall length.
- R7: A request presented during the done cycle is accepted at once. Stall (or done, for a zero count) follows in the next cycle, with no idle cycle in between.
- R8: A request presented while stall is high is ignored. After the current done pulse the block returns to idle.
- R9: Stall and done are never high together, and done lasts one cycle unless a new request arrives in the done cycle.
- R10: wdog_en always equals register bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal (undivided) clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Control register read data |
| acc_req | input | 1 | Access request strobe |
| acc_is_prog | input | 1 | 1 = program-memory access, 0 = data-memory access |
| stall | output | 1 | Hold the CPU; high during wait cycles |
| done | output | 1 | One-cycle access completion pulse |
| wdog_en | output | 1 | Stored watchdog-enable bit |

## Verification
On every cycle, the assertions check several properties:
- stall and done are mutually exclusive;
- done is a single pulse unless a request renews it;
- an idle request always leads to stall or done;
- a falling stall always lands on done;
- bit 7 reads zero;
- the watchdog output tracks bit 6.

The exact stall length for every count value and both access types can only be shown by the bench's scenarios. The same holds for the count being captured at the start of an access, zero-wait back-to-back chaining, and the ignoring of requests during a stall. The bench sweeps all 64 combinations of the two fields and computes the expected lengths arithmetically.

// File: rtl/memwait_pkg.sv
package memwait_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_t;
endpackage

// File: rtl/memwait_cfg_reg.sv
module memwait_cfg_reg #(
    parameter int WAIT_W = 3,
    localparam int REG_W = 2 * WAIT_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [WAIT_W-1:0] prog_wait,
    output logic [WAIT_W-1:0] data_wait,
    output logic              wdog_en
);
    // Reset value: every stored bit set (maximum waits, watchdog enabled)
    logic [REG_W-2:0] held_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_q <= '1;
        end else if (wr_en) begin
            held_q <= wr_data[REG_W-2:0];
        end
    end

    assign rd_data   = {1'b0, held_q};
    assign prog_wait = held_q[WAIT_W-1:0];
    assign data_wait = held_q[2*WAIT_W-1:WAIT_W];
    assign wdog_en   = held_q[2*WAIT_W];
endmodule

// File: rtl/memwait_seq.sv
module memwait_seq #(
    parameter int WAIT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_is_prog,
    input  logic [WAIT_W-1:0] prog_wait,
    input  logic [WAIT_W-1:0] data_wait,
    output logic              stall,
    output logic              done
);
    import memwait_pkg::*;

    seq_state_t        state_q, state_d;
    logic [WAIT_W-1:0] cnt_q;
    logic [WAIT_W-1:0] sel_wait;
    logic              accept;

    assign sel_wait = req_is_prog ? prog_wait : data_wait;
    assign accept   = req && (state_q != ST_WAIT);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (req) begin
                    state_d = (sel_wait == '0) ? ST_DONE : ST_WAIT;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_WAIT: begin
                if (cnt_q == WAIT_W'(1)) begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State and wait counter registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                cnt_q <= sel_wait;
            end else if (state_q == ST_WAIT) begin
                cnt_q <= cnt_q - WAIT_W'(1);
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        stall = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            ST_WAIT: stall = 1'b1;
            ST_DONE: done  = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/memwait_gen.sv
module memwait_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] cfg_rdata,
    input  logic       acc_req,
    input  logic       acc_is_prog,
    output logic       stall,
    output logic       done,
    output logic       wdog_en
);
    localparam int WAIT_W = 3;

    logic [WAIT_W-1:0] prog_wait;
    logic [WAIT_W-1:0] data_wait;

    memwait_cfg_reg #(.WAIT_W(WAIT_W)) cfg_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_data   (cfg_wdata),
        .rd_data   (cfg_rdata),
        .prog_wait (prog_wait),
        .data_wait (data_wait),
        .wdog_en   (wdog_en)
    );

    memwait_seq #(.WAIT_W(WAIT_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (acc_req),
        .req_is_prog (acc_is_prog),
        .prog_wait   (prog_wait),
        .data_wait   (data_wait),
        .stall       (stall),
        .done        (done)
    );
endmodule

// File: rtl/memwait_chk.sv
module memwait_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       acc_req,
    input logic       stall,
    input logic       done,
    input logic       wdog_en,
    input logic [7:0] cfg_rdata
);
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && done));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !acc_req) |=> !done);

    p_idle_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !done && acc_req) |=> (stall || done));

    p_stall_to_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> done);

    p_req_in_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && acc_req) |=> (stall || done));

    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[7] == 1'b0);

    p_wdog_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wdog_en == cfg_rdata[6]);
endmodule

bind memwait_gen memwait_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_req   (acc_req),
    .stall     (stall),
    .done      (done),
    .wdog_en   (wdog_en),
    .cfg_rdata (cfg_rdata)
);

// File: tb/memwait_gen_tb_top.sv
module memwait_gen_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       acc_req = 1'b0;
    logic       acc_is_prog = 1'b0;
    logic       stall, done, wdog_en;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2 clk = ~clk; // 250 MHz

    memwait_gen dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .acc_req(acc_req), .acc_is_prog(acc_is_prog),
        .stall(stall), .done(done), .wdog_en(wdog_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Issues a request at a negedge; returns the number of stall cycles seen,
    // leaving the caller at the negedge where done should be high.
    task automatic run_access(input bit prog, output int n);
        acc_req = 1'b1;
        acc_is_prog = prog;
        @(negedge clk);
        acc_req = 1'b0;
        n = 0;
        while (stall && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(cfg_rdata == 8'h7F, "R1 cfg reset", cfg_rdata, 8'h7F);
        check(wdog_en == 1'b1, "R1 wdog reset", wdog_en, 1);
        check(!stall && !done, "R1 stall/done reset", {stall, done}, 0);

        // R3/R4 at reset default: 7 waits
        run_access(1'b0, n);
        check(n == 7, "R3 default data waits", n, 7);
        check(done, "R3 done after stall", done, 1);
        @(negedge clk);
        check(!done && !stall, "R9 done single", {stall, done}, 0);

        // R2 bit 7 reserved; R10 watchdog follows bit 6
        write_cfg(8'hFF);
        check(cfg_rdata == 8'h7F, "R2 bit7 reads 0", cfg_rdata, 8'h7F);
        write_cfg(8'h8A);
        check(cfg_rdata == 8'h0A, "R2 write store", cfg_rdata, 8'h0A);
        check(wdog_en == 1'b0, "R10 wdog cleared", wdog_en, 0);

        // Exhaustive sweep of both fields, both access types
        for (int d = 0; d < 8; d++) begin
            for (int p = 0; p < 8; p++) begin
                logic [7:0] v;
                v = 8'((d << 3) | p | ((d & 1) << 6));
                write_cfg(v);
                check(cfg_rdata == v, "R2 sweep readback", cfg_rdata, v);
                check(wdog_en == v[6], "R10 sweep wdog", wdog_en, v[6]);
                run_access(1'b0, n);
                check(n == d, d == 0 ? "R5 data zero wait" : "R3 data waits", n, d);
                check(done && !stall, "R3 data done", {stall, done}, 1);
                @(negedge clk);
                check(!done, "R9 data done once", done, 0);
                run_access(1'b1, n);
                check(n == p, p == 0 ? "R5 prog zero wait" : "R4 prog waits", n, p);
                check(done && !stall, "R4 prog done", {stall, done}, 1);
                @(negedge clk);
                check(!done, "R9 prog done once", done, 0);
            end
        end

        // R6: count captured at start; write during access ignored for it
        write_cfg(8'h28); // data=5, prog=0
        acc_req = 1'b1; acc_is_prog = 1'b0;
        @(negedge clk);
        acc_req = 1'b0;
        cfg_we = 1'b1; cfg_wdata = 8'h00;
        n = 0;
        while (stall && n < 20) begin
            n++;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        check(n == 5, "R6 captured count", n, 5);
        check(cfg_rdata == 8'h00, "R6 write landed", cfg_rdata, 0);
        @(negedge clk);

        // R7: back-to-back with request in the done cycle
        write_cfg(8'h13); // data=2, prog=3
        run_access(1'b0, n);
        check(done, "R7 first done", done, 1);
        run_access(1'b1, n);
        check(n == 3, "R7 back-to-back prog waits", n, 3);
        check(done, "R7 second done", done, 1);
        run_access(1'b0, n);
        check(n == 2, "R7 chained data waits", n, 2);
        @(negedge clk);

        // R7 with zero count: done repeats immediately
        write_cfg(8'h10); // data=2, prog=0
        run_access(1'b1, n);
        check(n == 0 && done, "R7 zero first done", done, 1);
        run_access(1'b1, n);
        check(n == 0 && done, "R7 zero chained done", done, 1);
        @(negedge clk);
        check(!done, "R9 zero chain ends", done, 0);

        // R8: request while stalling is ignored
        write_cfg(8'h20); // data=4, prog=0
        acc_req = 1'b1; acc_is_prog = 1'b0;
        @(negedge clk);
        acc_req = 1'b0;
        @(negedge clk);
        acc_req = 1'b1; acc_is_prog = 1'b1; // in stall
        @(negedge clk);
        acc_req = 1'b0;
        n = 2;
        while (stall && n < 20) begin
            n++;
            @(negedge clk);
        end
        check(n == 4, "R8 stall length unchanged", n, 4);
        check(done, "R8 done reached", done, 1);
        @(negedge clk);
        check(!stall && !done, "R8 back to idle", {stall, done}, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule